// File: doc/BRIEF.md
# Per-Processor Free-Running User Counter Array

This block holds, for a set of processors, the counter path that runs once a processor's timer is taken out of interrupting limit operation and put into user operation. A single mode mask sits in the shared system timer, with one bit per processor. Setting a bit turns that processor's timer into a silent up-counter. The counter advances one unit per timebase tick, and one unit weighs bit 9 of a 64-bit value. Software reads the value as two 32-bit words and can start, stop or clear it. Any change to a processor's mode bit restarts that processor's counter from zero.

Every access uses one register port. A system/processor select and a processor index pick the target, and a 3-bit word index picks the register. The response is registered and appears one cycle after the request. The interrupt from the neighbouring limit timer passes through the block and is silenced for every processor in user mode. The mode mask is also driven out, so that the limit timers can tell which processors they own.

Top module: `ucnt_array_top`

## Requirements
- R1: A system-target write to word index 4 loads the mode mask from write data bits [NUM_CPUS-1:0], where bit i set means processor i is in user mode. A system-target read of word 4 returns the mask zero-extended to 32 bits. The mask is 0 after reset.
- R2: In the cycle after a write that changes mode bit i, processor i's count is zero and its running flag is 1, whichever way the bit moved. Processors whose bit did not change are unaffected.
- R3: While processor i is in user mode, irq_out[i] is 0. In limit mode, irq_out[i] equals lim_irq_in[i].
- R4: The counter value is the unit count shifted left by 9, giving 63 significant bits. In user mode a read of word 0 returns value bits [63:32], and bit 31 of that word is always 0. A read of word 1 returns value bits [31:0] with bits [8:0] zero.
- R5: A user-mode read of word 0 captures the current lower word. The next word-1 read of that processor returns the captured word and then discards it. A word-1 read with no captured word pending returns the live lower word.
- R6: A user-mode write to word 0 or word 1 sets the count to zero and discards any captured lower word. The written data is ignored and the running flag is unchanged.
- R7: A user-mode write to word 3 sets the running flag from write data bit 0, where 1 starts the counter and 0 stops it. A read of word 3 returns the running flag in bit 0 in either mode. The flag is 0 after reset.
- R8: A stopped counter holds its value across ticks. Starting it again resumes counting from the held value.
- R9: The count grows by exactly one unit on each clock where tick is 1, the processor is in user mode and its counter is running.
- R10: Word 4 exists only on the system target, and words 0, 1 and 3 exist only on processor targets. An access to a word that does not exist on the target reads 0 and a write to it has no effect. In limit mode, processor writes to words 0, 1 and 3 are ignored, and reads of words 0 and 1 return 0.
- R11: When a clearing write or a mode change falls in the same cycle as a counting tick, the count is zero afterwards. The tick is lost.
- R12: rsp_valid is 1 exactly one cycle after each request. rsp_data carries read data taken from the state at the request cycle, and is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one count unit per high cycle |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sys | input | 1 | 1 = system timer target, 0 = processor timer target |
| bus_cpu | input | CPU_IDX_W | Processor index for processor-target accesses |
| bus_word | input | 3 | Word index (0 upper, 1 lower, 3 run control, 4 mode mask) |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_data | output | 32 | Read data |
| lim_irq_in | input | NUM_CPUS | Interrupts from the limit timers |
| irq_out | output | NUM_CPUS | Interrupts after user-mode silencing |
| user_mode_o | output | NUM_CPUS | Current mode mask |

## Verification
Two events can collide in one clock: a counting tick and a count reset. The reset comes either from a clearing write to word 0 or 1, or from a mode-mask write that flips the processor's bit. The bench holds tick high across the clock that accepts such a write, and then reads the lower word. The affected processor must read exactly zero. Another user-mode processor that was not touched must show that same tick counted, with its bench-tracked count one higher.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  typedef enum logic [2:0] {
    W_HI   = 3'd0,
    W_LO   = 3'd1,
    W_RUN  = 3'd3,
    W_MODE = 3'd4
  } word_e;

  // Counter value from a unit count: units weigh 2**sh.
  function automatic logic [63:0] scale_units(input logic [63:0] units, input int unsigned sh);
    return units << sh;
  endfunction

  function automatic logic [31:0] hi_word(input logic [63:0] v);
    return v[63:32];
  endfunction

  // Lower word with the sub-unit bits forced to zero.
  function automatic logic [31:0] lo_word(input logic [63:0] v, input int unsigned sh);
    return v[31:0] & ~((32'd1 << sh) - 32'd1);
  endfunction

endpackage

// File: rtl/ucnt_mode_reg.sv
module ucnt_mode_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_mask,
  output logic [N-1:0] mode_q,
  output logic [N-1:0] chg_pulse
);

  assign chg_pulse = wr_en ? (wr_mask ^ mode_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_mask;
  end

endmodule

// File: rtl/ucnt_core.sv
module ucnt_core
  import ucnt_pkg::*;
#(
  parameter int CNT_W = 54,
  parameter int SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             user_mode,
  input  logic             mode_chg,
  input  logic             clr_req,
  input  logic             run_wr,
  input  logic             run_val,
  input  logic             snap_take,
  input  logic             snap_use,
  output logic [CNT_W-1:0] units,
  output logic [63:0]      value,
  output logic             running,
  output logic             snap_valid,
  output logic [31:0]      snap_lo,
  output logic             cnt_inc
);

  assign value   = scale_units(64'(units), SHIFT);
  assign cnt_inc = tick & running & user_mode & ~clr_req & ~mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units      <= '0;
      running    <= 1'b0;
      snap_valid <= 1'b0;
      snap_lo    <= '0;
    end else if (mode_chg) begin
      units      <= '0;
      running    <= 1'b1;
      snap_valid <= 1'b0;
    end else begin
      if (clr_req)      units <= '0;
      else if (cnt_inc) units <= units + 1'b1;
      if (run_wr) running <= run_val;
      if (clr_req) begin
        snap_valid <= 1'b0;
      end else if (snap_take) begin
        snap_valid <= 1'b1;
        snap_lo    <= lo_word(value, SHIFT);
      end else if (snap_use) begin
        snap_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ucnt_rsp.sv
module ucnt_rsp
  import ucnt_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int SHIFT = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic                 sys,
  input  logic [IDX_W-1:0]     cpu,
  input  logic [2:0]           word,
  input  logic [N-1:0]         mode_q,
  input  logic [N-1:0][63:0]   values,
  input  logic [N-1:0][31:0]   snaps,
  input  logic [N-1:0]         snap_valid,
  input  logic [N-1:0]         running,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_data
);

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (!we) begin
      if (sys) begin
        if (word == W_MODE) rd_mux = 32'(mode_q);
      end else if (32'(cpu) < N) begin
        unique case (word)
          W_HI:  if (mode_q[cpu]) rd_mux = hi_word(values[cpu]);
          W_LO:  if (mode_q[cpu]) rd_mux = snap_valid[cpu] ? snaps[cpu]
                                                           : lo_word(values[cpu], SHIFT);
          W_RUN: rd_mux = {31'd0, running[cpu]};
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req;
      rsp_data  <= req ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/ucnt_array_top.sv
module ucnt_array_top
  import ucnt_pkg::*;
#(
  parameter int NUM_CPUS   = 4,
  parameter int VAL_W      = 63,
  parameter int UNIT_SHIFT = 9,
  localparam int CNT_W     = VAL_W - UNIT_SHIFT,
  localparam int CPU_IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic                 bus_sys,
  input  logic [CPU_IDX_W-1:0] bus_cpu,
  input  logic [2:0]           bus_word,
  input  logic [31:0]          bus_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_data,
  input  logic [NUM_CPUS-1:0]  lim_irq_in,
  output logic [NUM_CPUS-1:0]  irq_out,
  output logic [NUM_CPUS-1:0]  user_mode_o
);

  // Named internal events, also observed by the bound checker.
  logic                          mode_wr;
  logic [NUM_CPUS-1:0]           mode_q;
  logic [NUM_CPUS-1:0]           mode_chg;
  logic [NUM_CPUS-1:0]           clr_evt;
  logic [NUM_CPUS-1:0]           run_wr;
  logic [NUM_CPUS-1:0]           snap_take;
  logic [NUM_CPUS-1:0]           snap_use;
  logic [NUM_CPUS-1:0]           running;
  logic [NUM_CPUS-1:0]           snap_valid;
  logic [NUM_CPUS-1:0]           cnt_inc;
  logic [NUM_CPUS-1:0][CNT_W-1:0] units_all;
  logic [NUM_CPUS-1:0][63:0]     values;
  logic [NUM_CPUS-1:0][31:0]     snaps;

  assign mode_wr = bus_req & bus_we & bus_sys & (bus_word == W_MODE);

  ucnt_mode_reg #(.N(NUM_CPUS)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (mode_wr),
    .wr_mask   (bus_wdata[NUM_CPUS-1:0]),
    .mode_q    (mode_q),
    .chg_pulse (mode_chg)
  );

  assign user_mode_o = mode_q;
  assign irq_out     = lim_irq_in & ~mode_q;

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic sel;
    assign sel          = bus_req & ~bus_sys & (bus_cpu == CPU_IDX_W'(i)) & mode_q[i];
    assign clr_evt[i]   = sel & bus_we & ((bus_word == W_HI) | (bus_word == W_LO));
    assign run_wr[i]    = sel & bus_we & (bus_word == W_RUN);
    assign snap_take[i] = sel & ~bus_we & (bus_word == W_HI);
    assign snap_use[i]  = sel & ~bus_we & (bus_word == W_LO);

    ucnt_core #(.CNT_W(CNT_W), .SHIFT(UNIT_SHIFT)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .user_mode  (mode_q[i]),
      .mode_chg   (mode_chg[i]),
      .clr_req    (clr_evt[i]),
      .run_wr     (run_wr[i]),
      .run_val    (bus_wdata[0]),
      .snap_take  (snap_take[i]),
      .snap_use   (snap_use[i]),
      .units      (units_all[i]),
      .value      (values[i]),
      .running    (running[i]),
      .snap_valid (snap_valid[i]),
      .snap_lo    (snaps[i]),
      .cnt_inc    (cnt_inc[i])
    );
  end

  ucnt_rsp #(.N(NUM_CPUS), .IDX_W(CPU_IDX_W), .SHIFT(UNIT_SHIFT)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (bus_req),
    .we         (bus_we),
    .sys        (bus_sys),
    .cpu        (bus_cpu),
    .word       (bus_word),
    .mode_q     (mode_q),
    .values     (values),
    .snaps      (snaps),
    .snap_valid (snap_valid),
    .running    (running),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
  parameter int N     = 4,
  parameter int CNT_W = 54
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  bus_req,
  input logic                  rsp_valid,
  input logic [N-1:0]          mode_q,
  input logic [N-1:0]          mode_chg,
  input logic [N-1:0]          clr_evt,
  input logic [N-1:0]          running,
  input logic [N-1:0]          irq_out,
  input logic [N-1:0][CNT_W-1:0] units_all
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid); // R12
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !rsp_valid); // R12

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_USER_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[i] |-> !irq_out[i]); // R3
    AST_CHG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg[i] |=> (units_all[i] == '0) && running[i]); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt[i] |=> (units_all[i] == '0)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && running[i] && mode_q[i] && !clr_evt[i] && !mode_chg[i])
        |=> units_all[i] == CNT_W'($past(units_all[i]) + 1'b1)); // R9
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      ((!running[i] || !tick || !mode_q[i]) && !clr_evt[i] && !mode_chg[i])
        |=> $stable(units_all[i])); // R8
  end

endmodule

bind ucnt_array_top ucnt_checker #(.N(NUM_CPUS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .bus_req   (bus_req),
  .rsp_valid (rsp_valid),
  .mode_q    (mode_q),
  .mode_chg  (mode_chg),
  .clr_evt   (clr_evt),
  .running   (running),
  .irq_out   (irq_out),
  .units_all (units_all)
);

// File: tb/ucnt_array_top_test.sv
`timescale 1ns/1ps
module ucnt_array_top_test;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_sys = 1'b0;
  logic [1:0]  bus_cpu = '0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [N-1:0] lim_irq_in = '1;
  logic [N-1:0] irq_out;
  logic [N-1:0] user_mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ucnt_array_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sys(bus_sys), .bus_cpu(bus_cpu),
    .bus_word(bus_word), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lim_irq_in(lim_irq_in), .irq_out(irq_out), .user_mode_o(user_mode_o)
  );

  // Bench restatement of the value layout: one unit is 512.
  function automatic logic [31:0] lo_of(input int unsigned n);
    return 32'(n * 512);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input bit sys, input int cpu, input int word,
                        input logic [31:0] wd, input bit tk, output logic [31:0] rd,
                        output logic vld);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_sys = sys; bus_cpu = 2'(cpu);
    bus_word = 3'(word); bus_wdata = wd; tick = tk;
    @(negedge clk);
    bus_req = 1'b0; tick = 1'b0;
    rd = rsp_data; vld = rsp_valid;
  endtask

  task automatic wr(input bit sys, input int cpu, input int word, input logic [31:0] wd,
                    input bit tk = 0);
    logic [31:0] d; logic v;
    access(1'b1, sys, cpu, word, wd, tk, d, v);
  endtask

  task automatic rd(input bit sys, input int cpu, input int word, output logic [31:0] d);
    logic v;
    access(1'b0, sys, cpu, word, '0, 1'b0, d, v);
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    access(1'b0, 1'b1, 0, 4, '0, 1'b0, d, v);
    check("R1 reset mode mask", d, 32'h0);
    check("R12 rsp_valid after read", 32'(v), 32'h1);
    rd(0, 0, 3, d);
    check("R7 reset running", d, 32'h0);
    check("R3 limit-mode irq passthrough", 32'(irq_out), 32'hF);
  endtask

  task automatic t_enter_user();
    logic [31:0] d;
    wr(1, 0, 4, 32'h5);
    check("R3 user-mode irq silenced", 32'(irq_out), 32'hA);
    rd(1, 0, 4, d);
    check("R1 mode read", d, 32'h5);
    rd(0, 0, 3, d);
    check("R2 restart sets running", d, 32'h1);
    rd(0, 1, 3, d);
    check("R2 unchanged cpu untouched", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    tick_n(10);
    rd(0, 0, 0, d);
    check("R4 upper word", d, 32'h0);
    rd(0, 0, 1, d);
    check("R9 ten ticks lower word", d, lo_of(10));
    rd(0, 1, 1, d);
    check("R10 limit-mode lower read zero", d, 32'h0);
  endtask

  task automatic t_stop_start();
    logic [31:0] d;
    wr(0, 0, 3, 32'h0);
    tick_n(5);
    rd(0, 0, 3, d);
    check("R7 stopped status", d, 32'h0);
    rd(0, 0, 1, d);
    check("R8 stopped holds", d, lo_of(10));
    wr(0, 0, 3, 32'h1);
    tick_n(3);
    rd(0, 0, 1, d);
    check("R8 resume from held", d, lo_of(13));
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, 0, 1, 32'hFFFF_FFFF);
    rd(0, 0, 1, d);
    check("R6 clear on write", d, 32'h0);
    rd(0, 0, 3, d);
    check("R6 running unchanged", d, 32'h1);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    rd(0, 2, 0, d);
    check("R4 cpu2 upper word", d, 32'h0);
    tick_n(4);
    rd(0, 2, 1, d);
    check("R5 captured lower word", d, lo_of(18));
    rd(0, 2, 1, d);
    check("R5 live after capture used", d, lo_of(22));
  endtask

  task automatic t_collide();
    logic [31:0] d;
    tick_n(2);
    wr(0, 0, 0, 32'h1234_5678, 1'b1);
    rd(0, 0, 1, d);
    check("R11 clear beats tick", d, 32'h0);
    wr(1, 0, 4, 32'hD, 1'b1);
    rd(0, 3, 1, d);
    check("R11 mode change beats tick", d, 32'h0);
    rd(0, 3, 3, d);
    check("R2 cpu3 running after entry", d, 32'h1);
    rd(0, 2, 1, d);
    check("R9 other cpu counted colliding tick", d, lo_of(26));
    check("R3 irq with mask D", 32'(irq_out), 32'h2);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(0, 1, 3, 32'h1);
    rd(0, 1, 3, d);
    check("R10 limit-mode start ignored", d, 32'h0);
    rd(0, 0, 4, d);
    check("R10 cpu word4 reads zero", d, 32'h0);
    rd(1, 0, 3, d);
    check("R10 system word3 reads zero", d, 32'h0);
    wr(0, 1, 4, 32'hF);
    rd(1, 0, 4, d);
    check("R10 cpu word4 write ignored", d, 32'hD);
  endtask

  task automatic t_leave();
    logic [31:0] d;
    wr(1, 0, 4, 32'h8);
    check("R3 irq after leaving user", 32'(irq_out), 32'h7);
    rd(0, 2, 3, d);
    check("R2 leave restarts running", d, 32'h1);
    tick_n(3);
    wr(1, 0, 4, 32'hC);
    rd(0, 2, 1, d);
    check("R2 re-entry starts at zero", d, 32'h0);
    tick_n(1);
    rd(0, 2, 1, d);
    check("R9 one tick after re-entry", d, lo_of(1));
    rd(0, 3, 1, d);
    check("R2 cpu3 unaffected by other bits", d, lo_of(4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enter_user();
    t_count();
    t_stop_start();
    t_clear();
    t_snapshot();
    t_collide();
    t_ignored();
    t_leave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule